// File: doc/BRIEF.md
# Per-Phase Proportional-Resonant Current Regulator

This block is the current regulator for one phase of a grid-tied inverter. It works in the stationary abc frame, so three copies of it serve a three-phase, four-wire converter. Once per sample strobe, nominally every 50 µs at a 20 MHz system clock, it takes three signed 16-bit words: a normalized current reference, the measured inverter-side inductor current and the grid phase voltage. It returns a normalized modulation command. The current words are normalized to a 15 A base.

The control law is a proportional gain plus an undamped resonant integrator tuned to the 50 Hz grid fundamental. It is built from two cross-coupled 32-bit state integrators. The grid voltage is added after the controller as a feedforward term, and the sum is clipped to the signed 16-bit range. The three coefficients arrive as configuration ports, already scaled by the sample period. One multiplier is shared across a six-cycle sequence, and a one-cycle done pulse marks each new command.

Top module: `pr_current_reg`

## Requirements
- R1: A synchronous reset clears both resonant states, the command output, the saturation flag and the done pulse to zero.
- R2: A sample strobe seen while idle starts one update. The done output goes high for exactly one cycle, with the new command, in the sixth cycle after the clock edge that took the strobe.
- R3: A strobe that arrives while an update is in progress is ignored: it yields no second done pulse and no extra state update.
- R4: The error is e = ref − meas, formed at 17 bits. The proportional term is (kpGain·e) >>> 12, so kpGain is signed Q4.12 (1.26 ≈ 5161).
- R5: The first state is updated as x1 ← clamp(x1 + ((kiGain·e) >>> 3) − ((wGain·x2) >>> 15)). kiGain and wGain are signed Q0.15 numbers already multiplied by the sample period. The states carry 27 fraction bits, 12 more than the data words.
- R6: The second state is updated as x2 ← clamp(x2 + ((wGain·x1) >>> 15)), using the x1 value just computed in the same update.
- R7: The command is p + (x1 >>> 12) + ff, clipped to [−32768, 32767]. satFlag is 1 exactly when clipping occurred.
- R8: Both states saturate to the signed 32-bit range and never wrap.
- R9: modCmd and satFlag hold their values between done pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleStrobe | input | 1 | Starts one controller update |
| refCurrent | input | 16 | Normalized current reference, signed Q1.15 |
| measCurrent | input | 16 | Normalized inverter-side current, signed Q1.15 |
| gridFf | input | 16 | Grid-voltage feedforward, signed Q1.15 |
| kpGain | input | 16 | Proportional gain, signed Q4.12 |
| kiGain | input | 16 | Resonant gain times sample period, signed Q0.15 |
| wGain | input | 16 | Resonant frequency times sample period, signed Q0.15 |
| modCmd | output | 16 | Modulation command, signed Q1.15 |
| satFlag | output | 1 | Last command was clipped |
| done | output | 1 | One-cycle pulse: new command valid |

## Verification
The bench builds the block with its default widths: 16-bit data, 32-bit state and 12 guard bits. It drives the nominal gains (5161, 1647, 514) through a table of operating points, so the resonant state rings for hundreds of samples and the bench model follows it bit for bit. Directed gain sets do two more things. A resonant gain of 32767 with the proportional path off drives the states into the 32-bit clamp, where a wrap would show up as a sign flip at the output. A wGain of 0.5 makes the order of the two state updates visible in the second output word.

// File: rtl/pr_pkg.sv
`timescale 1ns/1ps
package pr_pkg;

  // operand pair driven into the shared multiplier
  typedef enum logic [1:0] {
    SEL_KP_E  = 2'd0,
    SEL_KI_E  = 2'd1,
    SEL_W_X2  = 2'd2,
    SEL_W_X1  = 2'd3
  } mulSel_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic    capture;
    mulSel_e sel;
    logic    wrP;
    logic    wrAcc;
    logic    wrX1;
    logic    wrX2;
    logic    wrOut;
  } prStrobe_t;

endpackage

// File: rtl/pr_mult.sv
`timescale 1ns/1ps
module pr_mult #(
  parameter int A_W = 32,
  parameter int B_W = 16,
  localparam int P_W = A_W + B_W
) (
  input  logic signed [A_W-1:0] opA,
  input  logic signed [B_W-1:0] opB,
  output logic signed [P_W-1:0] prod
);

  logic signed [P_W-1:0] aWide;
  logic signed [P_W-1:0] bWide;

  always_comb begin
    aWide = {{B_W{opA[A_W-1]}}, opA};
    bWide = {{A_W{opB[B_W-1]}}, opB};
    prod  = aWide * bWide;
  end

endmodule

// File: rtl/pr_ctrl.sv
`timescale 1ns/1ps
module pr_ctrl
  import pr_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      sampleStrobe,
  output prStrobe_t stb
);

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PROP = 3'd1,
    ST_RES  = 3'd2,
    ST_X1   = 3'd3,
    ST_X2   = 3'd4,
    ST_OUT  = 3'd5
  } seqState_e;

  seqState_e state;
  seqState_e stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (sampleStrobe) stateNext = ST_PROP;
      ST_PROP: stateNext = ST_RES;
      ST_RES:  stateNext = ST_X1;
      ST_X1:   stateNext = ST_X2;
      ST_X2:   stateNext = ST_OUT;
      ST_OUT:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  always_comb begin
    stb = '0;
    unique case (state)
      ST_IDLE: stb.capture = sampleStrobe;
      ST_PROP: begin stb.sel = SEL_KP_E; stb.wrP   = 1'b1; end
      ST_RES:  begin stb.sel = SEL_KI_E; stb.wrAcc = 1'b1; end
      ST_X1:   begin stb.sel = SEL_W_X2; stb.wrX1  = 1'b1; end
      ST_X2:   begin stb.sel = SEL_W_X1; stb.wrX2  = 1'b1; end
      ST_OUT:  stb.wrOut = 1'b1;
      default: stb = '0;
    endcase
  end

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    stb.wrOut |-> $past(stb.capture, 5));

  // R3
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |=> !stb.wrP || $past(state == ST_OUT) == 1'b0);

  // R2
  one_write_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stb.wrP, stb.wrAcc, stb.wrX1, stb.wrX2, stb.wrOut}));

endmodule

// File: rtl/pr_datapath.sv
`timescale 1ns/1ps
module pr_datapath
  import pr_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int COEF_W    = 16,
  parameter int STATE_W   = 32,
  parameter int KP_FRAC   = 12,
  parameter int COEF_FRAC = 15,
  parameter int GUARD     = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  prStrobe_t                stb,
  input  logic signed [DATA_W-1:0] refCurrent,
  input  logic signed [DATA_W-1:0] measCurrent,
  input  logic signed [DATA_W-1:0] gridFf,
  input  logic signed [COEF_W-1:0] kpGain,
  input  logic signed [COEF_W-1:0] kiGain,
  input  logic signed [COEF_W-1:0] wGain,
  output logic signed [DATA_W-1:0] modCmd,
  output logic                     satFlag,
  output logic                     done
);

  localparam int ERR_W    = DATA_W + 1;
  localparam int PROD_W   = STATE_W + COEF_W;
  localparam int KI_SHIFT = COEF_FRAC - GUARD;
  localparam int RES_W    = STATE_W - GUARD;

  localparam logic signed [PROD_W-1:0] ST_MAX  = {{(PROD_W-STATE_W+1){1'b0}}, {(STATE_W-1){1'b1}}};
  localparam logic signed [PROD_W-1:0] ST_MIN  = {{(PROD_W-STATE_W+1){1'b1}}, {(STATE_W-1){1'b0}}};
  localparam logic signed [PROD_W-1:0] OUT_MAX = {{(PROD_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [PROD_W-1:0] OUT_MIN = {{(PROD_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};
  localparam logic signed [DATA_W-1:0] CMD_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] CMD_MIN = {1'b1, {(DATA_W-1){1'b0}}};

  function automatic logic signed [STATE_W-1:0] clampState(input logic signed [PROD_W-1:0] v);
    if (v > ST_MAX)      return ST_MAX[STATE_W-1:0];
    else if (v < ST_MIN) return ST_MIN[STATE_W-1:0];
    else                 return v[STATE_W-1:0];
  endfunction

  // registers
  logic signed [ERR_W-1:0]   eReg;
  logic signed [DATA_W-1:0]  ffReg;
  logic signed [PROD_W-1:0]  pReg;
  logic signed [PROD_W-1:0]  accReg;
  logic signed [STATE_W-1:0] x1;
  logic signed [STATE_W-1:0] x2;

  // shared multiplier
  logic signed [STATE_W-1:0] opA;
  logic signed [COEF_W-1:0]  opB;
  logic signed [PROD_W-1:0]  prod;

  always_comb begin
    unique case (stb.sel)
      SEL_KP_E: begin opA = {{(STATE_W-ERR_W){eReg[ERR_W-1]}}, eReg}; opB = kpGain; end
      SEL_KI_E: begin opA = {{(STATE_W-ERR_W){eReg[ERR_W-1]}}, eReg}; opB = kiGain; end
      SEL_W_X2: begin opA = x2; opB = wGain; end
      default:  begin opA = x1; opB = wGain; end
    endcase
  end

  pr_mult #(.A_W(STATE_W), .B_W(COEF_W)) uMult (
    .opA  (opA),
    .opB  (opB),
    .prod (prod)
  );

  // scaled products and update candidates
  logic signed [PROD_W-1:0]  prodKp;
  logic signed [PROD_W-1:0]  prodKi;
  logic signed [PROD_W-1:0]  prodW;
  logic signed [PROD_W-1:0]  x1Wide;
  logic signed [PROD_W-1:0]  x2Wide;
  logic signed [STATE_W-1:0] x1Shift;
  logic signed [PROD_W-1:0]  resWide;
  logic signed [PROD_W-1:0]  ffWide;
  logic signed [PROD_W-1:0]  sumWide;
  logic signed [ERR_W-1:0]   errNext;
  logic signed [DATA_W-1:0]  cmdNext;
  logic                      satNext;

  always_comb begin
    errNext = {refCurrent[DATA_W-1], refCurrent} - {measCurrent[DATA_W-1], measCurrent};
    prodKp  = prod >>> KP_FRAC;
    prodKi  = prod >>> KI_SHIFT;
    prodW   = prod >>> COEF_FRAC;
    x1Wide  = {{(PROD_W-STATE_W){x1[STATE_W-1]}}, x1};
    x2Wide  = {{(PROD_W-STATE_W){x2[STATE_W-1]}}, x2};
    x1Shift = x1 >>> GUARD;
    resWide = {{(PROD_W-RES_W){x1Shift[RES_W-1]}}, x1Shift[RES_W-1:0]};
    ffWide  = {{(PROD_W-DATA_W){ffReg[DATA_W-1]}}, ffReg};
    sumWide = pReg + resWide + ffWide;
    if (sumWide > OUT_MAX) begin
      cmdNext = CMD_MAX; satNext = 1'b1;
    end else if (sumWide < OUT_MIN) begin
      cmdNext = CMD_MIN; satNext = 1'b1;
    end else begin
      cmdNext = sumWide[DATA_W-1:0]; satNext = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      eReg    <= '0;
      ffReg   <= '0;
      pReg    <= '0;
      accReg  <= '0;
      x1      <= '0;
      x2      <= '0;
      modCmd  <= '0;
      satFlag <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= stb.wrOut;
      if (stb.capture) begin
        eReg  <= errNext;
        ffReg <= gridFf;
      end
      if (stb.wrP)   pReg   <= prodKp;
      if (stb.wrAcc) accReg <= x1Wide + prodKi;
      if (stb.wrX1)  x1     <= clampState(accReg - prodW);
      if (stb.wrX2)  x2     <= clampState(x2Wide + prodW);
      if (stb.wrOut) begin
        modCmd  <= cmdNext;
        satFlag <= satNext;
      end
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (modCmd == '0 && !satFlag && !done && x1 == '0 && x2 == '0));

  // R7
  sat_level_chk: assert property (@(posedge clk) disable iff (rst)
    satFlag |-> (modCmd == CMD_MAX || modCmd == CMD_MIN));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(modCmd) && $stable(satFlag)));

  // R2
  single_done_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6
  x2_after_x1_chk: assert property (@(posedge clk) disable iff (rst)
    stb.wrX2 |-> $past(stb.wrX1));

endmodule

// File: rtl/pr_current_reg.sv
`timescale 1ns/1ps
module pr_current_reg
  import pr_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int COEF_W    = 16,
  parameter int STATE_W   = 32,
  parameter int KP_FRAC   = 12,
  parameter int COEF_FRAC = 15,
  parameter int GUARD     = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sampleStrobe,
  input  logic signed [DATA_W-1:0] refCurrent,
  input  logic signed [DATA_W-1:0] measCurrent,
  input  logic signed [DATA_W-1:0] gridFf,
  input  logic signed [COEF_W-1:0] kpGain,
  input  logic signed [COEF_W-1:0] kiGain,
  input  logic signed [COEF_W-1:0] wGain,
  output logic signed [DATA_W-1:0] modCmd,
  output logic                     satFlag,
  output logic                     done
);

  prStrobe_t stb;

  pr_ctrl uCtrl (
    .clk          (clk),
    .rst          (rst),
    .sampleStrobe (sampleStrobe),
    .stb          (stb)
  );

  pr_datapath #(
    .DATA_W    (DATA_W),
    .COEF_W    (COEF_W),
    .STATE_W   (STATE_W),
    .KP_FRAC   (KP_FRAC),
    .COEF_FRAC (COEF_FRAC),
    .GUARD     (GUARD)
  ) uPath (
    .clk         (clk),
    .rst         (rst),
    .stb         (stb),
    .refCurrent  (refCurrent),
    .measCurrent (measCurrent),
    .gridFf      (gridFf),
    .kpGain      (kpGain),
    .kiGain      (kiGain),
    .wGain       (wGain),
    .modCmd      (modCmd),
    .satFlag     (satFlag),
    .done        (done)
  );

endmodule

// File: tb/pr_current_reg_test.sv
`timescale 1ns/1ps
module pr_current_reg_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sampleStrobe = 1'b0;
  logic signed [15:0] refCurrent = '0;
  logic signed [15:0] measCurrent = '0;
  logic signed [15:0] gridFf = '0;
  logic signed [15:0] kpGain = '0;
  logic signed [15:0] kiGain = '0;
  logic signed [15:0] wGain = '0;
  logic signed [15:0] modCmd;
  logic satFlag;
  logic done;

  always #2 clk = ~clk;  // 250 MHz

  pr_current_reg uut (
    .clk(clk), .rst(rst), .sampleStrobe(sampleStrobe),
    .refCurrent(refCurrent), .measCurrent(measCurrent), .gridFf(gridFf),
    .kpGain(kpGain), .kiGain(kiGain), .wGain(wGain),
    .modCmd(modCmd), .satFlag(satFlag), .done(done)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // reference model state
  longint mx1 = 0, mx2 = 0;
  int mkp = 0, mki = 0, mw = 0;
  bit hitClamp = 0;

  // stimulus table: ref, meas, ff, sample count
  localparam int NV = 8;
  localparam int TV_REF [NV] = '{0, 1000, -3000, 8000, 20000, -20000, 4000, 0};
  localparam int TV_MEAS[NV] = '{0, 200, 500, 8000, -20000, 20000, 0, 0};
  localparam int TV_FF  [NV] = '{0, 50, -1200, 0, 20000, -20000, 1000, 0};
  localparam int TV_CNT [NV] = '{4, 20, 30, 10, 5, 5, 200, 100};

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint sat32(input longint v);
    if (v > 64'sd2147483647) begin hitClamp = 1; return 64'sd2147483647; end
    if (v < -64'sd2147483648) begin hitClamp = 1; return -64'sd2147483648; end
    return v;
  endfunction

  task automatic modelStep(input int r, input int m, input int f, output int y, output bit s);
    longint e, p, t1, t2, sum;
    e = longint'(r) - longint'(m);
    p = (longint'(mkp) * e) >>> 12;
    t1 = (longint'(mki) * e) >>> 3;
    t2 = (longint'(mw) * mx2) >>> 15;
    mx1 = sat32(mx1 + t1 - t2);
    mx2 = sat32(mx2 + ((longint'(mw) * mx1) >>> 15));
    sum = p + (mx1 >>> 12) + longint'(f);
    s = 1;
    if (sum > 32767) y = 32767;
    else if (sum < -32768) y = -32768;
    else begin y = int'(sum); s = 0; end
  endtask

  task automatic setGains(input int kp, input int ki, input int w);
    @(negedge clk);
    kpGain = 16'(kp); kiGain = 16'(ki); wGain = 16'(w);
    mkp = kp; mki = ki; mw = w;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    mx1 = 0; mx2 = 0;
  endtask

  // one strobe, wait for done, check latency (R2)
  task automatic runSample(input int r, input int m, input int f);
    int lat;
    @(negedge clk);
    refCurrent = 16'(r); measCurrent = 16'(m); gridFf = 16'(f);
    sampleStrobe = 1'b1;
    @(negedge clk);
    sampleStrobe = 1'b0;
    lat = 1;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    check("R2 done latency", lat, 6);
  endtask

  task automatic sampleAndCompare(input string req, input int r, input int m, input int f);
    int y; bit s;
    runSample(r, m, f);
    modelStep(r, m, f, y, s);
    check(req, modCmd, y);
    check({req, " sat"}, satFlag, s);
  endtask

  initial begin
    int doneCount;
    int held;
    int y; bit s;

    repeat (4) @(negedge clk);
    // R1: reset state at the ports
    check("R1 cmd after reset", modCmd, 0);
    check("R1 sat after reset", satFlag, 0);
    check("R1 done after reset", done, 0);
    rst = 1'b0;

    // R4: proportional only, kp = 1.0
    setGains(4096, 0, 0);
    runSample(1000, 200, 50);
    check("R4 proportional plus ff", modCmd, 850);
    mx1 = 0; mx2 = 0;

    // R5: resonant only, ki = 0.125, w = 0
    doReset();
    setGains(0, 4096, 0);
    runSample(800, 0, 0);
    check("R5 first resonant step", modCmd, 100);
    runSample(800, 0, 0);
    check("R5 second resonant step", modCmd, 200);

    // R6: x2 uses the fresh x1, w = 0.5
    doReset();
    setGains(0, 4096, 16384);
    runSample(800, 0, 0);
    check("R6 first step", modCmd, 100);
    runSample(800, 0, 0);
    check("R6 update order", modCmd, 175);

    // table walk with nominal gains: R4 R5 R6 R7
    doReset();
    setGains(5161, 1647, 514);
    for (int i = 0; i < NV; i++) begin
      for (int k = 0; k < TV_CNT[i]; k++)
        sampleAndCompare("R4 R5 R6 R7 table", TV_REF[i], TV_MEAS[i], TV_FF[i]);
    end

    // R9: output holds between done pulses
    held = modCmd;
    repeat (5) @(negedge clk);
    check("R9 hold cmd", modCmd, held);

    // R3: strobe while busy is ignored
    @(negedge clk);
    refCurrent = 16'sd3000; measCurrent = 16'sd0; gridFf = 16'sd0;
    sampleStrobe = 1'b1;
    @(negedge clk);
    sampleStrobe = 1'b0;
    doneCount = 0;
    @(negedge clk);
    sampleStrobe = 1'b1;
    @(negedge clk);
    sampleStrobe = 1'b0;
    for (int c = 0; c < 20; c++) begin
      if (done) doneCount++;
      @(negedge clk);
    end
    check("R3 single done", doneCount, 1);
    modelStep(3000, 0, 0, y, s);
    check("R3 cmd after busy strobe", modCmd, y);
    sampleAndCompare("R3 state after busy strobe", 3000, 0, 0);

    // R8: drive the states into the clamp, proportional path off
    doReset();
    hitClamp = 0;
    setGains(0, 32767, 514);
    for (int k = 0; k < 400; k++)
      sampleAndCompare("R8 clamp run", 32767, -32768, 0);
    check("R8 clamp reached", hitClamp, 1);

    // R1: reset clears the ringing states
    doReset();
    @(negedge clk);
    check("R1 cmd cleared", modCmd, 0);
    setGains(5161, 1647, 514);
    runSample(0, 0, 0);
    check("R1 states cleared", modCmd, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule